// File: doc/BRIEF.md
# Delayed LMS Weight Update Unit

This unit holds the tap weights of an adaptive FIR filter and adapts them with the delayed least-mean-square rule. On every clock a new input sample enters a history line. An error value also arrives, produced by a separate error path a fixed number of cycles after the samples it depends on. The unit pairs that error with the samples of its own time step. For every tap it multiplies the two, scales the product down by a power-of-two step size, and adds the result to the stored weight. The sum saturates to the signed 8-bit weight word.

All taps adapt in parallel in a two-stage pipeline. The first stage registers the error-sample products. The second stage scales them, accumulates them and saturates the result. The weight vector drives the error path continuously. The error input is wider than the arithmetic uses, and its low bits are dropped before the multiply. A zero error leaves every weight where it is, so the filter keeps its present response.

Top module: `dlms_weight_update`

## Requirements
- R1: A synchronous active-high reset clears every weight, the sample history and the product stage to zero; `w_out` reads all zeros on the cycle after any reset edge.
- R2: In the absence of saturation, each tap weight after a clock edge equals its previous value plus the scaled product registered at the previous edge.
- R3: The error sampled at a clock edge is paired, for tap i, with the sample that was presented ADAPT_LAG + i edges earlier.
- R4: If the truncated error is zero, no weight changes two edges later, regardless of the samples or the step shift.
- R5: Only the upper 8 bits `err_in[11:4]` are used, as a signed value; bits [3:0] have no effect on any weight.
- R6: The registered 16-bit product is arithmetically shifted right by `mu_shift` (0 to 15) before it is added. Rounding is toward minus infinity, so -15 with a shift of 2 gives -4. The shift is sampled at the edge where the addition happens.
- R7: Weight addition saturates at +127 and -128 instead of wrapping.
- R8: An error sampled at edge t changes all taps together at edge t+1 and none of them at edge t.
- R9: Tap i occupies `w_out[i*8 +: 8]` as a two's-complement value. Samples on `x_in` are two's-complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 8 | Signed input sample, one per clock |
| err_in | input | 12 | Signed error from the error path; low 4 bits discarded |
| mu_shift | input | 4 | Step size as a right-shift count |
| w_out | output | NUM_TAPS*8 | Packed weight vector, tap 0 in the low byte |

## Verification
The bench builds the unit with four taps and an adaptation lag of two. With these values every tap position and the full lag window can be reached with short, hand-placed impulses, so the pairing of each error with its own sample can be checked tap by tap. The small tap count also lets full-scale samples and errors drive every weight into both saturation limits within a few cycles. A random phase across shifts from 3 to 8 then exercises mixed-sign accumulation against the cycle-accurate model.

// File: rtl/dlms_upd_pkg.sv
package dlms_upd_pkg;

    parameter int SMP_W    = 8;
    parameter int ERR_IN_W = 12;
    parameter int ERR_W    = 8;
    parameter int WGT_W    = 8;
    parameter int MU_W     = 4;

    localparam int PROD_W = SMP_W + ERR_W;
    localparam int SUM_W  = ((PROD_W > WGT_W) ? PROD_W : WGT_W) + 1;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [ERR_W-1:0]  err_t;
    typedef logic signed [WGT_W-1:0]  wgt_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic        [MU_W-1:0]   mu_t;

    // Control word shared by every tap lane
    typedef struct packed {
        err_t err;
        mu_t  mu;
    } adapt_ctl_t;

    localparam wgt_t WGT_MAX = {1'b0, {(WGT_W-1){1'b1}}};
    localparam wgt_t WGT_MIN = {1'b1, {(WGT_W-1){1'b0}}};

    // Keep the upper ERR_W bits of the incoming error
    function automatic err_t trunc_err(logic [ERR_IN_W-1:0] e);
        return err_t'(e[ERR_IN_W-1 -: ERR_W]);
    endfunction

    // Power-of-two step: arithmetic shift, floor rounding
    function automatic prod_t scale_prod(prod_t p, mu_t m);
        return p >>> m;
    endfunction

    function automatic prod_t mul_es(err_t e, smp_t s);
        return prod_t'(e) * prod_t'(s);
    endfunction

    // Saturating accumulate into the weight word
    function automatic wgt_t sat_add(wgt_t w, prod_t inc);
        sum_t s;
        s = sum_t'(w) + sum_t'(inc);
        if (s > sum_t'(WGT_MAX))
            return WGT_MAX;
        else if (s < sum_t'(WGT_MIN))
            return WGT_MIN;
        else
            return wgt_t'(s);
    endfunction

endpackage

// File: rtl/dlms_sample_line.sv
module dlms_sample_line
    import dlms_upd_pkg::*;
#(
    parameter int NUM_TAPS  = 8,
    parameter int ADAPT_LAG = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SMP_W-1:0]          x_in,
    output logic [NUM_TAPS*SMP_W-1:0] aligned_flat
);

    localparam int LINE_LEN = NUM_TAPS + ADAPT_LAG - 1;
    localparam int BASE     = ADAPT_LAG - 1;

    smp_t hist [LINE_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LINE_LEN; k++)
                hist[k] <= '0;
        end else begin
            hist[0] <= smp_t'(x_in);
            for (int k = 1; k < LINE_LEN; k++)
                hist[k] <= hist[k-1];
        end
    end

    // Tap i sees the sample presented ADAPT_LAG + i edges before the error
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_align
        assign aligned_flat[i*SMP_W +: SMP_W] = hist[BASE + i];
    end

endmodule

// File: rtl/dlms_tap_lane.sv
module dlms_tap_lane
    import dlms_upd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  adapt_ctl_t ctl,
    input  smp_t       smp,
    output prod_t      prod_q,
    output wgt_t       wgt_q
);

    // Stage 1: error times aligned sample
    always_ff @(posedge clk) begin
        if (rst)
            prod_q <= '0;
        else
            prod_q <= mul_es(ctl.err, smp);
    end

    // Stage 2: scale, accumulate, saturate
    always_ff @(posedge clk) begin
        if (rst)
            wgt_q <= '0;
        else
            wgt_q <= sat_add(wgt_q, scale_prod(prod_q, ctl.mu));
    end

endmodule

// File: rtl/dlms_weight_update.sv
module dlms_weight_update
    import dlms_upd_pkg::*;
#(
    parameter int NUM_TAPS  = 8,
    parameter int ADAPT_LAG = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SMP_W-1:0]          x_in,
    input  logic [ERR_IN_W-1:0]       err_in,
    input  logic [MU_W-1:0]           mu_shift,
    output logic [NUM_TAPS*WGT_W-1:0] w_out
);

    logic [NUM_TAPS*SMP_W-1:0]  aligned_flat;
    logic [NUM_TAPS*PROD_W-1:0] prod_flat;
    adapt_ctl_t                 ctl;

    assign ctl.err = trunc_err(err_in);
    assign ctl.mu  = mu_t'(mu_shift);

    dlms_sample_line #(
        .NUM_TAPS  (NUM_TAPS),
        .ADAPT_LAG (ADAPT_LAG)
    ) u_line (
        .clk          (clk),
        .rst          (rst),
        .x_in         (x_in),
        .aligned_flat (aligned_flat)
    );

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_lane
        prod_t lane_prod;
        wgt_t  lane_wgt;

        dlms_tap_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .smp    (smp_t'(aligned_flat[i*SMP_W +: SMP_W])),
            .prod_q (lane_prod),
            .wgt_q  (lane_wgt)
        );

        assign prod_flat[i*PROD_W +: PROD_W] = lane_prod;
        assign w_out[i*WGT_W +: WGT_W]       = lane_wgt;
    end

endmodule

// File: rtl/dlms_weight_update_chk.sv
module dlms_weight_update_chk
    import dlms_upd_pkg::*;
#(
    parameter int NUM_TAPS = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic [ERR_IN_W-1:0]        err_in,
    input logic [NUM_TAPS*WGT_W-1:0]  w_out,
    input logic [NUM_TAPS*PROD_W-1:0] prod_flat
);

    // Consecutive non-reset edges, capped at 3
    logic [1:0] live_q;
    always_ff @(posedge clk) begin
        if (rst)
            live_q <= '0;
        else if (live_q != 2'd3)
            live_q <= live_q + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (w_out == '0)); // R1

    AST_ZERO_ERR_PROD: assert property (@(posedge clk) disable iff (rst)
        (live_q >= 2'd1 && $past(err_in[ERR_IN_W-1 -: ERR_W]) == '0) |-> (prod_flat == '0)); // R4

    AST_ZERO_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (live_q >= 2'd2 && $past(err_in[ERR_IN_W-1 -: ERR_W], 2) == '0) |-> $stable(w_out)); // R4

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap_chk
        AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
            (live_q >= 2'd1 && !$past(prod_flat[i*PROD_W + PROD_W - 1]))
            |-> ($signed(w_out[i*WGT_W +: WGT_W]) >= $signed($past(w_out[i*WGT_W +: WGT_W])))); // R7

        AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
            (live_q >= 2'd1 && $past(prod_flat[i*PROD_W + PROD_W - 1]))
            |-> ($signed(w_out[i*WGT_W +: WGT_W]) <= $signed($past(w_out[i*WGT_W +: WGT_W])))); // R7
    end

endmodule

bind dlms_weight_update dlms_weight_update_chk #(
    .NUM_TAPS (NUM_TAPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .err_in    (err_in),
    .w_out     (w_out),
    .prod_flat (prod_flat)
);

// File: tb/dlms_weight_update_test.sv
module dlms_weight_update_test;

    localparam int N   = 4;
    localparam int LAG = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     x_in = '0;
    logic [11:0]    err_in = '0;
    logic [3:0]     mu_shift = '0;
    logic [N*8-1:0] w_out;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    cmp_on  = 1'b0;
    string cur_req = "R2";

    always #4 clk = ~clk;

    dlms_weight_update #(.NUM_TAPS(N), .ADAPT_LAG(LAG)) uut (
        .clk(clk), .rst(rst), .x_in(x_in), .err_in(err_in),
        .mu_shift(mu_shift), .w_out(w_out)
    );

    // Reference model: weights, pending products, sample history
    int mw[N];
    int mp[N];
    int xh[$];

    function automatic int sat8(int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int tap_out(int i);
        return int'($signed(w_out[i*8 +: 8]));
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin mw[i] = 0; mp[i] = 0; end
        for (int k = 0; k < N + LAG - 1; k++) xh.push_back(0);
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin mw[i] = 0; mp[i] = 0; end
            for (int k = 0; k < N + LAG - 1; k++) xh[k] = 0;
        end else begin
            int e;
            e = int'($signed(err_in[11:4]));   // R5
            for (int i = 0; i < N; i++) begin
                mw[i] = sat8(mw[i] + (mp[i] >>> mu_shift));  // R2 R6 R7
                mp[i] = e * xh[LAG - 1 + i];                  // R3
            end
            xh.push_front(int'($signed(x_in)));
            void'(xh.pop_back());
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int i = 0; i < N; i++) begin
                n_tests++;
                if (tap_out(i) !== mw[i]) begin
                    n_fail++;
                    $display("FAIL %s tap %0d: actual %0d expected %0d", cur_req, i, tap_out(i), mw[i]);
                end
            end
        end
    end

    task automatic step(input int x, input int e, input int m);
        @(negedge clk);
        x_in = 8'(x);
        err_in = 12'(e);
        mu_shift = 4'(m);
    endtask

    task automatic check_tap(input string req, input int i, input int exp);
        n_tests++;
        if (tap_out(i) !== exp) begin
            n_fail++;
            $display("FAIL %s tap %0d: actual %0d expected %0d", req, i, tap_out(i), exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x_in = '0; err_in = '0; mu_shift = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int snap[N];
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < N; i++) check_tap("R1", i, 0);
        cmp_on = 1'b1;

        // R3: impulse at sample k paired only with tap 2 via error LAG+2 later
        cur_req = "R3";
        step(1, 0, 0);
        for (int k = 0; k < LAG + 1; k++) step(0, 0, 0);
        step(0, 5 << 4, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        @(negedge clk);
        for (int i = 0; i < N; i++) check_tap("R3", i, (i == 2) ? 5 : 0);

        // R6/R8: constant sample 3, single error -5, shift 2 -> all taps -4 together
        do_reset();
        cur_req = "R6";
        for (int k = 0; k < N + LAG + 2; k++) step(3, 0, 2);
        step(3, (-5 * 16) & 12'hFFF, 2);
        step(3, 0, 2);
        for (int i = 0; i < N; i++) check_tap("R8", i, 0);
        step(3, 0, 2);
        for (int i = 0; i < N; i++) check_tap("R6", i, -4);

        // R7: drive to positive then negative limit
        cur_req = "R7";
        for (int k = 0; k < N + LAG + 6; k++) step(127, 127 << 4, 0);
        for (int i = 0; i < N; i++) check_tap("R7", i, 127);
        for (int k = 0; k < N + LAG + 6; k++) step(127, 12'h800, 0);
        for (int i = 0; i < N; i++) check_tap("R7", i, -128);

        // R5: only low error bits set -> weights untouched
        cur_req = "R5";
        for (int k = 0; k < 3; k++) step(0, 0, 0);
        for (int i = 0; i < N; i++) snap[i] = tap_out(i);
        for (int k = 0; k < 12; k++) step($urandom_range(0, 255), 12'h00F - k % 4, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        for (int i = 0; i < N; i++) check_tap("R5", i, snap[i]);

        // R4: zero error, random samples and shifts -> hold
        cur_req = "R4";
        for (int i = 0; i < N; i++) snap[i] = tap_out(i);
        for (int k = 0; k < 20; k++) step($urandom_range(0, 255), 0, $urandom_range(0, 15));
        for (int i = 0; i < N; i++) check_tap("R4", i, snap[i]);

        // R2/R9: random adaptation across shifts, compared every cycle
        do_reset();
        cur_req = "R2";
        for (int k = 0; k < 400; k++)
            step($urandom_range(0, 255), $urandom_range(0, 4095), $urandom_range(3, 8));
        step(0, 0, 4);
        step(0, 0, 4);
        @(negedge clk);
        for (int i = 0; i < N; i++) check_tap("R9", i, mw[i]);

        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule